// File: doc/BRIEF.md
# Thermal level hysteresis monitor

This block watches a stream of signed temperature samples from one sensor group and compares each accepted sample against a small set of programmable levels. Every level holds an upper threshold, a lower threshold, an enable and two 2-bit throttle-class codes, one for the CPU domain and one for the GPU domain. A level switches to its hot side when a sample reaches the upper threshold. It falls back to the cold side only once a sample drops below the lower threshold. While a level sits on its hot side and is enabled, its codes feed four throttle request lines: light and heavy, for the CPU and for the GPU.

Each level also reports where the latest sample fell relative to its band, as a 2-bit zone. It counts its crossings from cold to hot and from hot to cold in two saturating counters. A shared statistics control word enables counting per direction and clears the counters of a direction.

Software programs and observes the block through a plain register port. Writes take effect at a clock edge and reads are combinational. The sensor front end supplies samples with a one-cycle valid strobe.

Top module: `thermal_level_monitor`

## Requirements
- R1: After a synchronous reset, every level is disabled with thresholds zero and zone 0. All counters read zero, the statistics word reads zero and all four request outputs are low.
- R2: On a valid sample with the level enabled and the sample at or above the upper threshold, the level goes to its hot side. Its zone reads 3 after that clock edge.
- R3: On a valid sample that is below the upper threshold and not below the lower threshold, an enabled level keeps its previous side, including the requests it drives. Its zone reads 1.
- R4: On a valid sample below the lower threshold and below the upper threshold, an enabled level goes to its cold side. Its zone reads 0. Zone value 2 never appears.
- R5: While a level's enable is clear, samples change neither its zone, its side nor its counters, and it drives no request.
- R6: The control word of a level has the enable at bit 8, the CPU code at bits 6:5, the GPU code at bits 4:3 and the read-only zone at bits 1:0. Code bit 0 requests light and code bit 1 requests heavy (3 requests both). The requests of all enabled hot levels are ORed per output.
- R7: Cycles with the valid strobe low leave every zone, side, request and counter unchanged, whatever the temperature input carries.
- R8: A level's up counter adds one on each cold-to-hot change while statistics bit 0 is set. Its down counter adds one on each hot-to-cold change while bit 2 is set. Bits 0 and 2 read back.
- R9: Writing the statistics word with bit 1 set zeroes every up counter at that edge, and bit 3 does the same for every down counter. A clear wins over an increment at the same edge and leaves the other direction untouched. Bits 1 and 3 read as zero.
- R10: Counters stop at all ones and do not wrap.
- R11: With equal upper and lower thresholds, the band is empty. A sample at or above the value gives zone 3 and a sample below it gives zone 0, so the level toggles on every crossing.
- R12: Thresholds and samples compare as two's-complement signed numbers of THR_W bits.
- R13: Level n uses the byte addresses n*0x20 + {0x00 control, 0x04 upper threshold, 0x08 lower threshold, 0x0C up counter, 0x10 down counter}. The statistics word sits at 0x80 (default parameters). Thresholds read back sign-extended to 32 bits and counters zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Byte address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| temp_valid | input | 1 | Sample strobe |
| temp_in | input | THR_W (9) | Signed temperature sample |
| cpu_light_req | output | 1 | Light throttle request, CPU domain |
| cpu_heavy_req | output | 1 | Heavy throttle request, CPU domain |
| gpu_light_req | output | 1 | Light throttle request, GPU domain |
| gpu_heavy_req | output | 1 | Heavy throttle request, GPU domain |

## Verification
A sample presented with the strobe is taken at one rising edge. The zone, side, request lines and counters all show the new values right after that edge, with no further pipeline stage. A register write likewise lands at its edge, and a read returns data in the same cycle as the address. The bench changes inputs on falling edges and samples outputs and read data at the next falling edge, so every check looks exactly one edge after its stimulus. The cases where a clear meets an increment, where a sample lands on a threshold, and where thresholds are equal are each driven in a single cycle and checked at that edge.

// File: rtl/thermlvl_pkg.sv
// Shared constants and types of the thermal level monitor.
// Assumes a 32-bit register data path and a 0x20-byte window per level.
package thermlvl_pkg;
    localparam int REG_DATA_W       = 32;
    localparam int LEVEL_STRIDE_LSB = 5;     // 0x20 bytes per level

    localparam logic [LEVEL_STRIDE_LSB-1:0] OFF_CTRL   = 5'h00;
    localparam logic [LEVEL_STRIDE_LSB-1:0] OFF_UP_THR = 5'h04;
    localparam logic [LEVEL_STRIDE_LSB-1:0] OFF_DN_THR = 5'h08;
    localparam logic [LEVEL_STRIDE_LSB-1:0] OFF_UP_CNT = 5'h0C;
    localparam logic [LEVEL_STRIDE_LSB-1:0] OFF_DN_CNT = 5'h10;

    localparam int CTRL_EN_BIT  = 8;
    localparam int CTRL_CPU_LSB = 5;
    localparam int CTRL_GPU_LSB = 3;

    localparam int STAT_EN_UP  = 0;
    localparam int STAT_CLR_UP = 1;
    localparam int STAT_EN_DN  = 2;
    localparam int STAT_CLR_DN = 3;

    typedef enum logic [1:0] {
        ZONE_LO   = 2'd0,
        ZONE_BAND = 2'd1,
        ZONE_RSVD = 2'd2,
        ZONE_HI   = 2'd3
    } zone_e;
endpackage

// File: rtl/thermlvl_satcnt.sv
// Saturating event counter with synchronous clear.
// Assumes clear has priority over increment in the same cycle.
module thermlvl_satcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count one event per cycle, hold at the top, zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != CNT_MAX)) begin
            count <= count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/thermlvl_level.sv
// One threshold level: configuration registers, hysteresis side tracking,
// zone reporting and the two crossing counters.
// Assumes samples and thresholds are two's complement of THR_W bits and that
// the upper threshold takes priority when both compares hit.
module thermlvl_level
    import thermlvl_pkg::*;
#(
    parameter int THR_W = 9,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             ctrl_en_d,
    input  logic [1:0]       ctrl_cpu_d,
    input  logic [1:0]       ctrl_gpu_d,
    input  logic             up_wr,
    input  logic             dn_wr,
    input  logic [THR_W-1:0] thr_d,
    input  logic             temp_valid,
    input  logic [THR_W-1:0] temp_in,
    input  logic             cnt_up_en,
    input  logic             cnt_dn_en,
    input  logic             clr_up,
    input  logic             clr_dn,
    output logic             en_o,
    output logic [1:0]       cpu_code_o,
    output logic [1:0]       gpu_code_o,
    output logic [1:0]       status_o,
    output logic             hi_o,
    output logic [THR_W-1:0] up_thr_o,
    output logic [THR_W-1:0] dn_thr_o,
    output logic [CNT_W-1:0] up_cnt_o,
    output logic [CNT_W-1:0] dn_cnt_o
);
    logic       en_q;
    logic [1:0] cpu_q;
    logic [1:0] gpu_q;
    logic [THR_W-1:0] up_q;
    logic [THR_W-1:0] dn_q;
    zone_e      zone_q;
    logic       hi_q;
    logic       at_or_above_up;
    logic       below_dn;
    logic       take;
    logic       rise;
    logic       fall;

    // Control word fields: enable and the two throttle-class codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            cpu_q <= 2'b00;
            gpu_q <= 2'b00;
        end else if (ctrl_wr) begin
            en_q  <= ctrl_en_d;
            cpu_q <= ctrl_cpu_d;
            gpu_q <= ctrl_gpu_d;
        end
    end

    // Threshold registers, written independently.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q <= '0;
            dn_q <= '0;
        end else begin
            if (up_wr) up_q <= thr_d;
            if (dn_wr) dn_q <= thr_d;
        end
    end

    // Signed comparisons of the sample against both thresholds.
    always_comb begin
        at_or_above_up = $signed(temp_in) >= $signed(up_q);
        below_dn       = $signed(temp_in) <  $signed(dn_q);
        take           = temp_valid && en_q;
        rise           = take && at_or_above_up && !hi_q;
        fall           = take && !at_or_above_up && below_dn && hi_q;
    end

    // Hysteresis side and zone update on accepted samples only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zone_q <= ZONE_LO;
            hi_q   <= 1'b0;
        end else if (take) begin
            if (at_or_above_up) begin
                zone_q <= ZONE_HI;
                hi_q   <= 1'b1;
            end else if (below_dn) begin
                zone_q <= ZONE_LO;
                hi_q   <= 1'b0;
            end else begin
                zone_q <= ZONE_BAND;
            end
        end
    end

    thermlvl_satcnt #(.CNT_W(CNT_W)) u_up_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_up),
        .inc   (rise && cnt_up_en),
        .count (up_cnt_o)
    );

    thermlvl_satcnt #(.CNT_W(CNT_W)) u_dn_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_dn),
        .inc   (fall && cnt_dn_en),
        .count (dn_cnt_o)
    );

    // Expose state to the register read path and the request merge.
    always_comb begin
        en_o       = en_q;
        cpu_code_o = cpu_q;
        gpu_code_o = gpu_q;
        status_o   = zone_q;
        hi_o       = hi_q;
        up_thr_o   = up_q;
        dn_thr_o   = dn_q;
    end
endmodule

// File: rtl/thermlvl_req_merge.sv
// Combines the throttle codes of all active levels into four request lines.
// Assumes code bit 0 means light and code bit 1 means heavy.
module thermlvl_req_merge #(
    parameter int NUM_LEVELS = 4
) (
    input  logic [NUM_LEVELS-1:0]       active,
    input  logic [NUM_LEVELS-1:0][1:0]  cpu_code,
    input  logic [NUM_LEVELS-1:0][1:0]  gpu_code,
    output logic                        cpu_light,
    output logic                        cpu_heavy,
    output logic                        gpu_light,
    output logic                        gpu_heavy
);
    logic [1:0] cpu_acc;
    logic [1:0] gpu_acc;

    // OR the codes of every active level per domain.
    always_comb begin
        cpu_acc = 2'b00;
        gpu_acc = 2'b00;
        for (int i = 0; i < NUM_LEVELS; i++) begin
            if (active[i]) begin
                cpu_acc = cpu_acc | cpu_code[i];
                gpu_acc = gpu_acc | gpu_code[i];
            end
        end
        cpu_light = cpu_acc[0];
        cpu_heavy = cpu_acc[1];
        gpu_light = gpu_acc[0];
        gpu_heavy = gpu_acc[1];
    end
endmodule

// File: rtl/thermal_level_monitor.sv
// Top of the thermal level monitor: register decode and read mux, the
// statistics control word, one instance per level and the request merge.
// Assumes a single sensor group, byte addresses and combinational reads.
module thermal_level_monitor
    import thermlvl_pkg::*;
#(
    parameter int NUM_LEVELS = 4,
    parameter int THR_W      = 9,
    parameter int CNT_W      = 16,
    localparam int LVL_SEL_W = $clog2(NUM_LEVELS),
    localparam int ADDR_W    = LEVEL_STRIDE_LSB + LVL_SEL_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr_en,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [REG_DATA_W-1:0]   reg_wdata,
    output logic [REG_DATA_W-1:0]   reg_rdata,
    input  logic                    temp_valid,
    input  logic signed [THR_W-1:0] temp_in,
    output logic                    cpu_light_req,
    output logic                    cpu_heavy_req,
    output logic                    gpu_light_req,
    output logic                    gpu_heavy_req
);
    logic                          global_sel;
    logic                          stats_sel;
    logic [LVL_SEL_W-1:0]          lvl_idx;
    logic [LEVEL_STRIDE_LSB-1:0]   reg_off;
    logic                          stat_en_up;
    logic                          stat_en_dn;
    logic                          clr_up;
    logic                          clr_dn;
    logic                          wdata_unused;

    logic [NUM_LEVELS-1:0]             lvl_en;
    logic [NUM_LEVELS-1:0]             lvl_hi;
    logic [NUM_LEVELS-1:0][1:0]        lvl_cpu;
    logic [NUM_LEVELS-1:0][1:0]        lvl_gpu;
    logic [NUM_LEVELS-1:0][1:0]        lvl_status;
    logic [NUM_LEVELS-1:0][THR_W-1:0]  lvl_up_thr;
    logic [NUM_LEVELS-1:0][THR_W-1:0]  lvl_dn_thr;
    logic [NUM_LEVELS-1:0][CNT_W-1:0]  lvl_up_cnt;
    logic [NUM_LEVELS-1:0][CNT_W-1:0]  lvl_dn_cnt;

    // Address split into region, level index and in-level offset.
    always_comb begin
        global_sel = reg_addr[ADDR_W-1];
        stats_sel  = global_sel && (reg_addr[ADDR_W-2:0] == '0);
        lvl_idx    = reg_addr[LEVEL_STRIDE_LSB +: LVL_SEL_W];
        reg_off    = reg_addr[LEVEL_STRIDE_LSB-1:0];
        clr_up     = reg_wr_en && stats_sel && reg_wdata[STAT_CLR_UP];
        clr_dn     = reg_wr_en && stats_sel && reg_wdata[STAT_CLR_DN];
    end

    assign wdata_unused = ^reg_wdata;

    // Statistics enables, kept until rewritten.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_en_up <= 1'b0;
            stat_en_dn <= 1'b0;
        end else if (reg_wr_en && stats_sel) begin
            stat_en_up <= reg_wdata[STAT_EN_UP];
            stat_en_dn <= reg_wdata[STAT_EN_DN];
        end
    end

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_level
        logic lvl_wr;
        assign lvl_wr = reg_wr_en && !global_sel && (lvl_idx == LVL_SEL_W'(g));

        thermlvl_level #(
            .THR_W (THR_W),
            .CNT_W (CNT_W)
        ) u_level (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctrl_wr    (lvl_wr && (reg_off == OFF_CTRL)),
            .ctrl_en_d  (reg_wdata[CTRL_EN_BIT]),
            .ctrl_cpu_d (reg_wdata[CTRL_CPU_LSB +: 2]),
            .ctrl_gpu_d (reg_wdata[CTRL_GPU_LSB +: 2]),
            .up_wr      (lvl_wr && (reg_off == OFF_UP_THR)),
            .dn_wr      (lvl_wr && (reg_off == OFF_DN_THR)),
            .thr_d      (reg_wdata[THR_W-1:0]),
            .temp_valid (temp_valid),
            .temp_in    (temp_in),
            .cnt_up_en  (stat_en_up),
            .cnt_dn_en  (stat_en_dn),
            .clr_up     (clr_up),
            .clr_dn     (clr_dn),
            .en_o       (lvl_en[g]),
            .cpu_code_o (lvl_cpu[g]),
            .gpu_code_o (lvl_gpu[g]),
            .status_o   (lvl_status[g]),
            .hi_o       (lvl_hi[g]),
            .up_thr_o   (lvl_up_thr[g]),
            .dn_thr_o   (lvl_dn_thr[g]),
            .up_cnt_o   (lvl_up_cnt[g]),
            .dn_cnt_o   (lvl_dn_cnt[g])
        );
    end

    thermlvl_req_merge #(.NUM_LEVELS(NUM_LEVELS)) u_merge (
        .active    (lvl_en & lvl_hi),
        .cpu_code  (lvl_cpu),
        .gpu_code  (lvl_gpu),
        .cpu_light (cpu_light_req),
        .cpu_heavy (cpu_heavy_req),
        .gpu_light (gpu_light_req),
        .gpu_heavy (gpu_heavy_req)
    );

    // Read mux: statistics word or the addressed level field.
    always_comb begin
        reg_rdata = '0;
        if (stats_sel) begin
            reg_rdata[STAT_EN_UP] = stat_en_up;
            reg_rdata[STAT_EN_DN] = stat_en_dn;
        end
        for (int i = 0; i < NUM_LEVELS; i++) begin
            if (!global_sel && (lvl_idx == LVL_SEL_W'(i))) begin
                case (reg_off)
                    OFF_CTRL: begin
                        reg_rdata[CTRL_EN_BIT]        = lvl_en[i];
                        reg_rdata[CTRL_CPU_LSB +: 2]  = lvl_cpu[i];
                        reg_rdata[CTRL_GPU_LSB +: 2]  = lvl_gpu[i];
                        reg_rdata[1:0]                = lvl_status[i];
                    end
                    OFF_UP_THR: reg_rdata = {{(REG_DATA_W-THR_W){lvl_up_thr[i][THR_W-1]}}, lvl_up_thr[i]};
                    OFF_DN_THR: reg_rdata = {{(REG_DATA_W-THR_W){lvl_dn_thr[i][THR_W-1]}}, lvl_dn_thr[i]};
                    OFF_UP_CNT: reg_rdata = {{(REG_DATA_W-CNT_W){1'b0}}, lvl_up_cnt[i]};
                    OFF_DN_CNT: reg_rdata = {{(REG_DATA_W-CNT_W){1'b0}}, lvl_dn_cnt[i]};
                    default:    reg_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/thermlvl_checker.sv
// Property checker for the thermal level monitor, bound to the top module.
// Assumes the level state vectors of the top are visible to the bind.
module thermlvl_checker #(
    parameter int NUM_LEVELS = 4,
    parameter int THR_W      = 9,
    parameter int CNT_W      = 16
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             temp_valid,
    input logic [THR_W-1:0]                 temp_in,
    input logic [NUM_LEVELS-1:0]            lvl_en,
    input logic [NUM_LEVELS-1:0]            lvl_hi,
    input logic [NUM_LEVELS-1:0][1:0]       lvl_status,
    input logic [NUM_LEVELS-1:0][THR_W-1:0] lvl_up_thr,
    input logic [NUM_LEVELS-1:0][THR_W-1:0] lvl_dn_thr,
    input logic [NUM_LEVELS-1:0][CNT_W-1:0] lvl_up_cnt,
    input logic [NUM_LEVELS-1:0][CNT_W-1:0] lvl_dn_cnt,
    input logic                             clr_up,
    input logic                             clr_dn,
    input logic [3:0]                       req_vec
);
    // Any request needs an enabled level on its hot side (R6).
    p_req_needs_hot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vec != 4'b0000) |-> ((lvl_en & lvl_hi) != '0));

    for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_chk
        p_hi_at_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (temp_valid && lvl_en[i] && ($signed(temp_in) >= $signed(lvl_up_thr[i])))
            |=> (lvl_status[i] == 2'd3) && lvl_hi[i]);

        p_band_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (temp_valid && lvl_en[i] && ($signed(temp_in) < $signed(lvl_up_thr[i]))
             && !($signed(temp_in) < $signed(lvl_dn_thr[i])))
            |=> (lvl_status[i] == 2'd1) && $stable(lvl_hi[i]));

        p_lo_below_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (temp_valid && lvl_en[i] && ($signed(temp_in) < $signed(lvl_up_thr[i]))
             && ($signed(temp_in) < $signed(lvl_dn_thr[i])))
            |=> (lvl_status[i] == 2'd0) && !lvl_hi[i]);

        p_no_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
            lvl_status[i] != 2'd2);

        p_off_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !lvl_en[i] |=> $stable(lvl_status[i]) && $stable(lvl_hi[i]));

        p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !temp_valid |=> $stable(lvl_status[i]) && $stable(lvl_hi[i]));

        p_up_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (lvl_up_cnt[i] == $past(lvl_up_cnt[i]))
                  || (lvl_up_cnt[i] == $past(lvl_up_cnt[i]) + CNT_W'(1))
                  || (lvl_up_cnt[i] == '0));

        p_clr_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
            clr_up |=> lvl_up_cnt[i] == '0);

        p_clr_dn_r9: assert property (@(posedge clk) disable iff (!rst_n)
            clr_dn |=> lvl_dn_cnt[i] == '0);

        p_up_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ((lvl_up_cnt[i] == '1) && !clr_up) |=> lvl_up_cnt[i] == '1);

        p_dn_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ((lvl_dn_cnt[i] == '1) && !clr_dn) |=> lvl_dn_cnt[i] == '1);
    end
endmodule

bind thermal_level_monitor thermlvl_checker #(
    .NUM_LEVELS (NUM_LEVELS),
    .THR_W      (THR_W),
    .CNT_W      (CNT_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .temp_valid (temp_valid),
    .temp_in    (temp_in),
    .lvl_en     (lvl_en),
    .lvl_hi     (lvl_hi),
    .lvl_status (lvl_status),
    .lvl_up_thr (lvl_up_thr),
    .lvl_dn_thr (lvl_dn_thr),
    .lvl_up_cnt (lvl_up_cnt),
    .lvl_dn_cnt (lvl_dn_cnt),
    .clr_up     (clr_up),
    .clr_dn     (clr_dn),
    .req_vec    ({cpu_heavy_req, cpu_light_req, gpu_heavy_req, gpu_light_req})
);

// File: tb/tb_thermal_level_monitor.sv
// Directed bench: one task per scenario, each checking its own results.
// Inputs change on falling edges; outputs are sampled one edge later.
module tb_thermal_level_monitor;
    localparam int ADDR_W = 8;
    localparam int THR_W  = 9;
    localparam int CNT_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              temp_valid = 1'b0;
    logic signed [THR_W-1:0] temp_in = '0;
    logic cpu_light_req, cpu_heavy_req, gpu_light_req, gpu_heavy_req;

    int num_checks = 0;
    int num_fail   = 0;

    always #4 clk = ~clk;   // 125 MHz

    thermal_level_monitor #(.NUM_LEVELS(4), .THR_W(THR_W), .CNT_W(CNT_W)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr_en     (reg_wr_en),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .temp_valid    (temp_valid),
        .temp_in       (temp_in),
        .cpu_light_req (cpu_light_req),
        .cpu_heavy_req (cpu_heavy_req),
        .gpu_light_req (gpu_light_req),
        .gpu_heavy_req (gpu_heavy_req)
    );

    function automatic logic [ADDR_W-1:0] la(input int lvl, input int off);
        return ADDR_W'(lvl * 32 + off);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        num_checks++;
        if (act !== exp) begin
            num_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input int d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = 32'(d);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic smp(input int t);
        @(negedge clk);
        temp_valid = 1'b1; temp_in = THR_W'(t);
        @(negedge clk);
        temp_valid = 1'b0;
    endtask

    // Request vector order: {cpu_heavy, cpu_light, gpu_heavy, gpu_light}.
    task automatic req_chk(input string req, input logic [3:0] exp);
        chk(req, {28'b0, cpu_heavy_req, cpu_light_req, gpu_heavy_req, gpu_light_req}, {28'b0, exp});
    endtask

    task automatic setup_level(input int lvl, input int up, input int dn, input int ctrl);
        wr(la(lvl, 4), up);
        wr(la(lvl, 8), dn);
        wr(la(lvl, 0), ctrl);
    endtask

    task automatic t_reset;
        for (int l = 0; l < 4; l++) begin
            rd_chk("R1 ctrl", la(l, 0), 32'h0);
            rd_chk("R1 up cnt", la(l, 12), 32'h0);
            rd_chk("R1 dn cnt", la(l, 16), 32'h0);
        end
        rd_chk("R1 stats", 8'h80, 32'h0);
        req_chk("R1 requests", 4'b0000);
    endtask

    task automatic t_hysteresis;
        wr(8'h80, 'hF);
        setup_level(0, 50, 40, 'h130);
        smp(30); rd_chk("R4 below", la(0, 0), 32'h130); req_chk("R4 no req", 4'b0000);
        smp(45); rd_chk("R3 band from lo", la(0, 0), 32'h131); req_chk("R3 stays lo", 4'b0000);
        smp(50); rd_chk("R2 at up", la(0, 0), 32'h133); req_chk("R6 cpu light gpu heavy", 4'b0110);
        smp(45); rd_chk("R3 band from hi", la(0, 0), 32'h131); req_chk("R3 stays hi", 4'b0110);
        smp(40); rd_chk("R4 at dn holds", la(0, 0), 32'h131); req_chk("R4 at dn holds req", 4'b0110);
        smp(39); rd_chk("R4 below dn", la(0, 0), 32'h130); req_chk("R4 req off", 4'b0000);
        rd_chk("R8 up count", la(0, 12), 32'd1);
        rd_chk("R8 dn count", la(0, 16), 32'd1);
    endtask

    task automatic t_valid_gate;
        smp(60);
        @(negedge clk);
        temp_valid = 1'b0; temp_in = '0;
        repeat (3) @(negedge clk);
        rd_chk("R7 zone kept", la(0, 0), 32'h133);
        req_chk("R7 req kept", 4'b0110);
        rd_chk("R7 dn count kept", la(0, 16), 32'd1);
        smp(0);
        rd_chk("R7 valid sample lands", la(0, 0), 32'h130);
    endtask

    task automatic t_disable;
        wr(la(0, 0), 'h030);
        smp(60);
        rd_chk("R5 zone held", la(0, 0), 32'h030);
        req_chk("R5 no req", 4'b0000);
        rd_chk("R5 counter held", la(0, 12), 32'd2);
        wr(la(0, 0), 'h130);
        req_chk("R5 reenable still lo", 4'b0000);
    endtask

    task automatic t_merge;
        setup_level(0, 50, 40, 'h120);
        setup_level(2, 100, 90, 'h158);
        smp(0);
        smp(60);  req_chk("R6 one level", 4'b0100);
        smp(120); req_chk("R6 two levels ORed", 4'b1111);
        smp(95);  req_chk("R6 band keeps both", 4'b1111);
        rd_chk("R3 level2 band", la(2, 0), 32'h159);
        smp(0);   req_chk("R6 all off", 4'b0000);
        wr(la(2, 0), 0);
    endtask

    task automatic t_counters;
        setup_level(0, 50, 40, 'h130);
        smp(0);
        wr(8'h80, 'hB);
        rd_chk("R9 up cleared", la(0, 12), 32'd0);
        rd_chk("R9 dn cleared", la(0, 16), 32'd0);
        rd_chk("R8 stats readback", 8'h80, 32'h1);
        smp(60); rd_chk("R8 up counts", la(0, 12), 32'd1);
        smp(0);  rd_chk("R8 dn disabled", la(0, 16), 32'd0);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 8'h80; reg_wdata = 32'h3;
        temp_valid = 1'b1; temp_in = THR_W'(60);
        @(negedge clk);
        reg_wr_en = 1'b0; temp_valid = 1'b0;
        rd_chk("R9 clear beats inc", la(0, 12), 32'd0);
        rd_chk("R2 hi during clear", la(0, 0), 32'h133);
        wr(8'h80, 'h5);
        smp(0);  rd_chk("R8 dn counts", la(0, 16), 32'd1);
        smp(60); rd_chk("R8 up again", la(0, 12), 32'd1);
        wr(8'h80, 'hD);
        rd_chk("R9 dn cleared only", la(0, 16), 32'd0);
        rd_chk("R9 up untouched", la(0, 12), 32'd1);
        rd_chk("R9 clear bits read zero", 8'h80, 32'h5);
    endtask

    task automatic t_saturate;
        wr(8'h80, 'hF);
        for (int k = 0; k < 17; k++) begin
            smp(0);
            smp(60);
        end
        rd_chk("R10 up saturates", la(0, 12), 32'd15);
        rd_chk("R10 dn saturates", la(0, 16), 32'd15);
        wr(la(0, 0), 0);
    endtask

    task automatic t_equal;
        setup_level(3, 20, 20, 'h140);
        smp(0);  rd_chk("R11 start lo", la(3, 0), 32'h140);
        smp(20); rd_chk("R11 at value hi", la(3, 0), 32'h143); req_chk("R11 heavy", 4'b1000);
        smp(19); rd_chk("R11 below lo", la(3, 0), 32'h140); req_chk("R11 off", 4'b0000);
        smp(20); rd_chk("R11 toggles back", la(3, 0), 32'h143);
        smp(25); rd_chk("R11 no band", la(3, 0), 32'h143);
        wr(la(3, 0), 0);
    endtask

    task automatic t_signed;
        setup_level(1, -10, -20, 'h108);
        rd_chk("R13 up thr sign ext", la(1, 4), 32'hFFFF_FFF6);
        rd_chk("R13 dn thr sign ext", la(1, 8), 32'hFFFF_FFEC);
        smp(-100); rd_chk("R12 very cold", la(1, 0), 32'h108);
        smp(-5);   rd_chk("R12 neg above up", la(1, 0), 32'h10B); req_chk("R12 gpu light", 4'b0001);
        smp(-15);  rd_chk("R12 neg band", la(1, 0), 32'h109);
        smp(-25);  rd_chk("R12 neg below dn", la(1, 0), 32'h108);
        smp(5);    rd_chk("R12 positive above neg up", la(1, 0), 32'h10B);
        rd_chk("R13 other level untouched", la(2, 4), 32'd100);
    endtask

    logic done = 1'b0;

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hysteresis();
        t_valid_gate();
        t_disable();
        t_merge();
        t_counters();
        t_saturate();
        t_equal();
        t_signed();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", num_checks, num_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            num_checks++;
            num_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", num_checks, num_fail);
            $finish;
        end
    end
endmodule